// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Limiter

This block sits between the modulator and the gate drive of one output channel of a switching power stage. In normal operation it passes the PWM command straight through. When the channel's overcurrent comparator fires, the block takes over the drive. It inverts the output level at once, then flips it again on every third switching-period strobe. While it is only limiting it raises no fault. Only this channel is affected.

A timer runs while limiting continues. If limiting outlasts a trip time, set in system-clock cycles, the block latches a shutdown request and puts the output in high impedance. Only a RESET pulse releases the latch. Limiting ends without any outside action once a whole switching period passes with the comparator quiet. The overcurrent input must already be synchronous to `clk`. `period_stb` pulses for one clock once per switching period.

Top module: `cbc_limiter`

## Requirements
- R1: While `rst_n` is low, `pwm_oe`, `pwm_out`, `limiting` and `shutdown_req` are all 0 (asynchronously). The output is enabled from the first rising clock edge after `rst_n` goes high.
- R2: With no limiting and no shutdown, `pwm_out` equals `pwm_in` in the same cycle, `pwm_oe` is 1 and `limiting` is 0.
- R3: `oc_in` high at a rising edge while not limiting sets `limiting` after that edge. From then on, `pwm_out` is the inverse of the `pwm_in` level sampled at that edge, whatever `pwm_in` does afterwards.
- R4: While limiting, the forced level inverts at the 3rd, 6th, 9th … `period_stb` pulse counted from entry. Other cycles leave it unchanged.
- R5: Limiting ends at the edge that samples a `period_stb`, provided `oc_in` was low in every cycle since the previous strobe (or since entry). `oc_in` high in a strobe cycle counts toward the period that this strobe closes. From the next cycle, `pwm_out` follows `pwm_in` again.
- R6: An episode of limiting that is no longer than `TRIP_CYCLES` cycles never raises `shutdown_req`. Each new episode times from zero.
- R7: If `limiting` stays high for `TRIP_CYCLES+1` consecutive cycles, `shutdown_req` rises at the next edge. From then on `pwm_oe`, `pwm_out` and `limiting` are 0.
- R8: `shutdown_req` stays high whatever `oc_in`, `pwm_in` and `period_stb` do. Only `rst_n` low clears it, and normal pass-through resumes after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; low holds the output in high impedance |
| period_stb | input | 1 | One-cycle pulse once per switching period |
| oc_in | input | 1 | Synchronized overcurrent comparator level |
| pwm_in | input | 1 | PWM command from the modulator |
| pwm_out | output | 1 | Drive level to the output stage (0 when disabled) |
| pwm_oe | output | 1 | Output enable; 0 means high impedance |
| limiting | output | 1 | Cycle-by-cycle limiting in progress |
| shutdown_req | output | 1 | Latched overcurrent shutdown request |

## Verification
- **Stuck episode flag:** a limiting flag that sticks or clears early shows on `pwm_out` within one cycle of the strobe that should end it, because pass-through does or does not resume there.
- **Phase counter off by one:** a wrong count moves the forced inversion away from the third strobe. This is seen at the very strobe where the flip was due.
- **Trip timer fault:** a timer that does not restart per episode, or that is off by one, moves the rise of `shutdown_req` by whole cycles. It can also raise a false trip during a later short episode.
- **Leaky shutdown latch:** a latch that lets go shows up as `pwm_oe` coming back on the cycle after the stray input.

// File: rtl/ocl_pkg.sv
package ocl_pkg;

    // Episode tracking state: limiting flag and "overcurrent seen this period".
    typedef struct packed {
        logic active;
        logic seen;
    } episode_t;

    // Top-level run gate, set on the first edge after reset release.
    typedef struct packed {
        logic run;
    } gate_t;

    // Source selected for the output stage.
    typedef enum logic [1:0] {
        DRV_OFF   = 2'd0,
        DRV_PASS  = 2'd1,
        DRV_FORCE = 2'd2
    } drive_mode_e;

endpackage

// File: rtl/ocl_episode.sv
module ocl_episode
    import ocl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic oc,
    input  logic kill,
    output logic active,
    output logic start
);

    episode_t ep_d, ep_q;
    logic     period_hit;

    always_comb begin
        ep_d       = ep_q;
        start      = 1'b0;
        period_hit = ep_q.seen | oc;
        if (kill) begin
            ep_d = '0;
        end else begin
            start       = ~ep_q.active & oc;
            ep_d.active = ep_q.active | oc;
            if (stb) begin
                ep_d.seen = 1'b0;
                if (!period_hit) begin
                    ep_d.active = 1'b0;
                end
            end else begin
                ep_d.seen = period_hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ep_q <= '0;
        end else begin
            ep_q <= ep_d;
        end
    end

    assign active = ep_q.active;

    // Limiting may only end on a strobe edge or on shutdown.
    assert_hold_between_strobes_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ep_q.active && !stb && !kill) |=> ep_q.active
    );

    // Limiting only begins when the comparator is high.
    assert_entry_needs_oc_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!ep_q.active && !oc) |=> !ep_q.active
    );

endmodule

// File: rtl/ocl_cadence.sv
module ocl_cadence #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic active,
    input  logic start,
    input  logic pwm_in,
    output logic level
);

    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          level;
    } cad_t;

    cad_t cad_d, cad_q;

    always_comb begin
        cad_d = cad_q;
        if (start) begin
            cad_d.phase = '0;
            cad_d.level = ~pwm_in;
        end else if (!active) begin
            cad_d.phase = '0;
        end else if (stb) begin
            if (cad_q.phase == LAST) begin
                cad_d.phase = '0;
                cad_d.level = ~cad_q.level;
            end else begin
                cad_d.phase = cad_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cad_q <= '0;
        end else begin
            cad_q <= cad_d;
        end
    end

    assign level = cad_q.level;

    assert_phase_range_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        int'(cad_q.phase) < DIV
    );

    // The forced level never moves between strobes while limiting.
    assert_level_steady_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (active && !stb) |=> $stable(cad_q.level)
    );

endmodule

// File: rtl/ocl_duration.sv
module ocl_duration #(
    parameter int TRIP_CYCLES = 425000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic shut
);

    localparam int CW = $clog2(TRIP_CYCLES + 1);
    localparam logic [CW-1:0] TOP = CW'(TRIP_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          shut;
    } dur_t;

    dur_t dur_d, dur_q;

    always_comb begin
        dur_d = dur_q;
        if (active) begin
            if (dur_q.cnt != TOP) begin
                dur_d.cnt = dur_q.cnt + 1'b1;
            end
            if (dur_q.cnt == TOP) begin
                dur_d.shut = 1'b1;
            end
        end else begin
            dur_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dur_q <= '0;
        end else begin
            dur_q <= dur_d;
        end
    end

    assign shut = dur_q.shut;

    assert_shut_latched_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        dur_q.shut |=> dur_q.shut
    );

    assert_no_trip_idle_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!dur_q.shut && !active) |=> !dur_q.shut
    );

    assert_count_bounded_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        dur_q.cnt <= TOP
    );

endmodule

// File: rtl/cbc_limiter.sv
module cbc_limiter
    import ocl_pkg::*;
#(
    parameter int TRIP_CYCLES = 425000,
    parameter int CADENCE_DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_stb,
    input  logic oc_in,
    input  logic pwm_in,
    output logic pwm_out,
    output logic pwm_oe,
    output logic limiting,
    output logic shutdown_req
);

    gate_t       gate_d, gate_q;
    drive_mode_e mode;
    logic        ep_active;
    logic        ep_start;
    logic        forced_level;
    logic        shut;

    ocl_episode u_episode (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (period_stb),
        .oc     (oc_in),
        .kill   (shut),
        .active (ep_active),
        .start  (ep_start)
    );

    ocl_cadence #(.DIV(CADENCE_DIV)) u_cadence (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (period_stb),
        .active (ep_active),
        .start  (ep_start),
        .pwm_in (pwm_in),
        .level  (forced_level)
    );

    ocl_duration #(.TRIP_CYCLES(TRIP_CYCLES)) u_duration (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (ep_active),
        .shut   (shut)
    );

    always_comb begin
        gate_d     = gate_q;
        gate_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    always_comb begin
        if (!gate_q.run || shut) begin
            mode = DRV_OFF;
        end else if (ep_active) begin
            mode = DRV_FORCE;
        end else begin
            mode = DRV_PASS;
        end
        case (mode)
            DRV_PASS:  begin pwm_out = pwm_in;       pwm_oe = 1'b1; end
            DRV_FORCE: begin pwm_out = forced_level; pwm_oe = 1'b1; end
            default:   begin pwm_out = 1'b0;         pwm_oe = 1'b0; end
        endcase
    end

    assign limiting     = ep_active & ~shut;
    assign shutdown_req = shut;

    // A trip is only ever preceded by limiting.
    assert_trip_after_limit_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> $past(limiting)
    );

endmodule

// File: tb/cbc_limiter_test.sv
module cbc_limiter_test;

    localparam int TH = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic period_stb = 1'b0;
    logic oc_in = 1'b0;
    logic pwm_in = 1'b0;
    logic pwm_out, pwm_oe, limiting, shutdown_req;

    always #2 clk = ~clk;

    cbc_limiter #(.TRIP_CYCLES(TH), .CADENCE_DIV(3)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_stb   (period_stb),
        .oc_in        (oc_in),
        .pwm_in       (pwm_in),
        .pwm_out      (pwm_out),
        .pwm_oe       (pwm_oe),
        .limiting     (limiting),
        .shutdown_req (shutdown_req)
    );

    typedef struct {
        int    at;
        logic  [3:0] val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   fails = 0;
    bit   done = 0;

    // Monitor: samples 1 ns after each rising edge, pops due items.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            while (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                logic [3:0] act;
                e   = q.pop_front();
                act = {pwm_out, pwm_oe, limiting, shutdown_req};
                total++;
                if (e.at != cyc || act !== e.val) begin
                    fails++;
                    $display("FAIL %s cycle %0d: {out,oe,lim,shut} actual %b expected %b",
                             e.tag, cyc, act, e.val);
                end
            end
        end
    end

    task automatic push(input logic o, input logic oe, input logic l, input logic s,
                        input string tag);
        exp_t e;
        e.at  = cyc + 1;
        e.val = {o, oe, l, s};
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drive(input logic r, input logic oc, input logic stb, input logic p);
        rst_n      = r;
        oc_in      = oc;
        period_stb = stb;
        pwm_in     = p;
    endtask

    // R2: plain pass-through with strobes running.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            logic p;
            p = ((i / 2) % 2) == 1;
            drive(1'b1, 1'b0, (i % 5) == 4, p);
            push(p, 1'b1, 1'b0, 1'b0, "R2");
            @(negedge clk);
        end
    endtask

    // Episode: entry at i=0, oc high for i<=k, strobe every 5 cycles.
    task automatic episode(input logic p0, input int k, input int n);
        int pr;
        int clr;
        int sat;
        pr  = ((k + 4) / 5) * 5;
        if (pr < 5) pr = 5;
        clr = pr + 5;
        sat = (clr > TH) ? TH + 1 : 1 << 30;
        for (int i = 0; i <= n; i++) begin
            logic p;
            logic lvl;
            p   = (((i / 2) % 2) == 1) ^ p0;
            lvl = ~p0 ^ (((i / 15) % 2) == 1);
            drive(1'b1, i <= k, (i > 0) && (i % 5 == 0), p);
            if (i >= sat)
                push(1'b0, 1'b0, 1'b0, 1'b1, (i == sat) ? "R7" : "R8");
            else if (i < clr)
                push(lvl, 1'b1, 1'b1, 1'b0,
                     (i == 0) ? "R3" : (i >= 15) ? "R4" : (i == clr - 1) ? "R6" : "R3");
            else
                push(p, 1'b1, 1'b0, 1'b0, (i == clr) ? "R5" : "R2");
            @(negedge clk);
        end
    endtask

    initial begin
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        // R1: reset holds everything off, even with stimulus present
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, i[0], i[1], 1'b1);
            push(1'b0, 1'b0, 1'b0, 1'b0, "R1");
            @(negedge clk);
        end
        drive(1'b1, 1'b0, 1'b0, 1'b1);
        push(1'b1, 1'b1, 1'b0, 1'b0, "R1");
        @(negedge clk);
        idle(12);
        episode(1'b1, 0, 15);     // single-cycle pulse, clears at second strobe
        idle(7);
        episode(1'b1, 20, 30);
        idle(6);
        episode(1'b0, 35, 45);    // longer episode; timer must have restarted
        idle(6);
        episode(1'b1, 100, 100);  // trips
        // R8: latched despite quiet comparator, strobes and new pulses
        for (int i = 0; i < 30; i++) begin
            drive(1'b1, (i % 7) == 3, (i % 5) == 0, i[0]);
            push(1'b0, 1'b0, 1'b0, 1'b1, "R8");
            @(negedge clk);
        end
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        push(1'b0, 1'b0, 1'b0, 1'b0, "R8");
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        push(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        @(negedge clk);
        idle(8);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule